// File: doc/BRIEF.md
# GPIO Wakeup Edge Detector

This block watches five banks of wakeup-capable GPIO pins while the chip sits in a low-power mode. Each pin goes through a two-stage synchronizer. Any change of level, rising or falling, sets a sticky flag for that pin in its bank's status word. Software reads the flags through a small register port and clears them by writing ones. A single control input clears every bank at once.

Each bank also has an enable word. The block raises one registered wakeup interrupt when three things hold together: a flag is set, its matching enable bit is set, and the external global GPIO wakeup enable input is high. A flag is latched whether or not its enable bit is set. The enable only decides whether that flag can drive the interrupt.

Top module: `gpio_wake_monitor`

## Requirements
- R1: A low-to-high change on a pin sets that pin's status bit. The bit is readable after the third rising clock edge that follows the change: two synchronizer stages, then the edge compare.
- R2: A high-to-low change on a pin also sets that pin's status bit, with the same latency as R1.
- R3: Writing a status word clears every bit written as one. Bits written as zero keep their value.
- R4: When a pin edge and a write-one-to-clear reach the same status bit in the same cycle, the edge wins and the bit stays set.
- R5: Edges are recorded in the status word whatever the state of the enable word.
- R6: `wake_irq_o` is registered. It is high in the cycle after any bank holds a status bit that is set with its enable bit also set while `global_wake_en_i` is high. It goes low one cycle after that condition stops.
- R7: While `status_reset_i` is high at a clock edge, every status bit in all banks is cleared. This clear also beats an edge arriving in the same cycle.
- R8: Banks 0 to 4 hold 32, 10, 8, 2 and 2 pins. They take `pins_i` bits [31:0], [41:32], [49:42], [51:50] and [53:52], with the lowest pin at bit 0 of the word. Bank n's status word is at byte address 0x04+8n and its enable word at 0x08+8n.
- R9: All registers reset to zero. Bits above a bank's pin count read as zero and ignore writes. Addresses outside the map read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 54 | Wakeup-capable pin levels, all banks packed |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| global_wake_en_i | input | 1 | Global GPIO wakeup enable |
| status_reset_i | input | 1 | Clears all status words |
| wake_irq_o | output | 1 | Wakeup interrupt |

## Verification
A status register holding a wrong value shows up on the next read of its word and also on `wake_irq_o` one cycle later, if the bit is enabled. A fault in the synchronizer or the edge detector moves the moment a flag appears. Because of that, the bench reads only after the three-edge latency and drives a clear exactly on the third edge to expose the R4 priority. Errors in address decoding or bit masking appear on the read port straight away, since read data is combinational.

// File: rtl/gwm_pkg.sv
`timescale 1ns/1ps
package gwm_pkg;
  localparam int NUM_BANKS = 5;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int BANK_PINS [NUM_BANKS] = '{32, 10, 8, 2, 2};

  // Lowest pins_i index that belongs to bank n.
  function automatic int pin_base(input int n);
    int s;
    s = 0;
    for (int i = 0; i < n; i++) s += BANK_PINS[i];
    return s;
  endfunction

  localparam int TOTAL_PINS = pin_base(NUM_BANKS);

  function automatic logic [ADDR_W-1:0] status_addr(input int n);
    return ADDR_W'(4 + 8 * n);
  endfunction

  function automatic logic [ADDR_W-1:0] enable_addr(input int n);
    return ADDR_W'(8 + 8 * n);
  endfunction
endpackage

// File: rtl/gwm_edge_sync.sv
`timescale 1ns/1ps
module gwm_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // Either direction of change counts.
  assign edge_o = sync_q ^ prev_q;
endmodule

// File: rtl/gwm_bank_regs.sv
`timescale 1ns/1ps
module gwm_bank_regs
  import gwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     edge_i,
  input  logic             st_wr_i,
  input  logic             en_wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             clr_all_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] enable_o,
  output logic             pending_o
);
  logic [W-1:0] st_q, en_q, w1c, st_d;

  assign w1c = st_wr_i ? wdata_i : '0;

  always_comb begin
    if (clr_all_i) st_d = '0;
    else           st_d = (st_q & ~w1c) | edge_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  always_comb begin
    status_o = '0;
    enable_o = '0;
    status_o[W-1:0] = st_q;
    enable_o[W-1:0] = en_q;
  end

  assign pending_o = |(st_q & en_q);

  // Edges land in status regardless of enable and of a same-cycle clear.
  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i && !clr_all_i) |=> ((st_q & $past(edge_i)) == $past(edge_i)));

  assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && !clr_all_i) |=>
      ((st_q & $past(st_q & ~wdata_i)) == $past(st_q & ~wdata_i)));

  assert_one_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && !clr_all_i) |=> ((st_q & $past(wdata_i & ~edge_i)) == '0));

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (st_q == '0));
endmodule

// File: rtl/gwm_irq_merge.sv
`timescale 1ns/1ps
module gwm_irq_merge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pending_i,
  input  logic         global_en_i,
  output logic         irq_o
);
  logic fire;
  assign fire = global_en_i && (|pending_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= fire;
  end

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (global_en_i && |pending_i) |=> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(global_en_i && |pending_i) |=> !irq_o);
endmodule

// File: rtl/gpio_wake_monitor.sv
`timescale 1ns/1ps
module gpio_wake_monitor
  import gwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TOTAL_PINS-1:0] pins_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic                  global_wake_en_i,
  input  logic                  status_reset_i,
  output logic                  wake_irq_o
);
  logic [REG_W-1:0]     st_word [NUM_BANKS];
  logic [REG_W-1:0]     en_word [NUM_BANKS];
  logic [NUM_BANKS-1:0] pending;
  logic [NUM_BANKS-1:0] st_hit, en_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W  = BANK_PINS[b];
    localparam int LO = pin_base(b);
    logic [W-1:0] edges;

    assign st_hit[b] = (reg_addr_i == status_addr(b));
    assign en_hit[b] = (reg_addr_i == enable_addr(b));

    gwm_edge_sync #(.W(W)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins_i[LO +: W]),
      .edge_o (edges)
    );

    gwm_bank_regs #(.W(W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (edges),
      .st_wr_i   (reg_wr_i && st_hit[b]),
      .en_wr_i   (reg_wr_i && en_hit[b]),
      .wdata_i   (reg_wdata_i[W-1:0]),
      .clr_all_i (status_reset_i),
      .status_o  (st_word[b]),
      .enable_o  (en_word[b]),
      .pending_o (pending[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st_hit[b]) reg_rdata_o = st_word[b];
      if (en_hit[b]) reg_rdata_o = en_word[b];
    end
  end

  gwm_irq_merge #(.N(NUM_BANKS)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending_i   (pending),
    .global_en_i (global_wake_en_i),
    .irq_o       (wake_irq_o)
  );

  // A single address never decodes to two registers (R8).
  assert_one_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_hit, en_hit}));

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !global_wake_en_i |=> !wake_irq_o);
endmodule

// File: tb/gpio_wake_monitor_tb.sv
`timescale 1ns/1ps
module gpio_wake_monitor_tb;
  localparam int NP = 54;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NP-1:0] pins = '0;
  logic [7:0]    addr = '0;
  logic          wr = 0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          gen = 0;
  logic          sreset = 0;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  logic [NP-1:0] m_st = '0, m_en = '0;

  always #4 clk = ~clk;

  gpio_wake_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .global_wake_en_i(gen), .status_reset_i(sreset), .wake_irq_o(irq));

  function automatic int bw(input int b);
    case (b) 0: return 32; 1: return 10; 2: return 8; default: return 2; endcase
  endfunction
  function automatic int blo(input int b);
    case (b) 0: return 0; 1: return 32; 2: return 42; 3: return 50; default: return 52; endcase
  endfunction
  function automatic logic [31:0] word_of(input logic [NP-1:0] v, input int b);
    logic [31:0] r = '0;
    for (int i = 0; i < bw(b); i++) r[i] = v[blo(b) + i];
    return r;
  endfunction
  function automatic logic exp_irq();
    return gen && |(m_st & m_en);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic clr_model(input int b, input logic [31:0] d);
    for (int i = 0; i < bw(b); i++) if (d[i]) m_st[blo(b) + i] = 1'b0;
  endtask
  task automatic en_model(input int b, input logic [31:0] d);
    for (int i = 0; i < bw(b); i++) m_en[blo(b) + i] = d[i];
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    m_st = m_st | (pins ^ v);
    pins = v;
    cyc(4);
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int b = 0; b < 5; b++) begin
      reg_read(8'(4 + 8 * b), d); check(req, d, word_of(m_st, b));
      reg_read(8'(8 + 8 * b), d); check(req, d, word_of(m_en, b));
    end
    check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    cyc(3); rst_n = 1; cyc(2);

    // R9: reset values
    check_all("R9 reset");

    // R8 R9: masks, map, unmapped addresses
    for (int b = 0; b < 5; b++) begin
      reg_write(8'(8 + 8 * b), 32'hFFFF_FFFF); en_model(b, 32'hFFFF_FFFF);
      reg_read(8'(8 + 8 * b), d);
      check("R9 upper bits", d, (bw(b) == 32) ? 32'hFFFF_FFFF : ((32'd1 << bw(b)) - 1));
    end
    reg_read(8'h00, d); check("R9 unmapped 00", d, 0);
    reg_read(8'h2C, d); check("R9 unmapped 2C", d, 0);
    reg_read(8'h06, d); check("R9 unmapped 06", d, 0);
    for (int b = 0; b < 5; b++) begin reg_write(8'(8 + 8 * b), 0); en_model(b, 0); end

    // R1 R5: rising edge on bank1 pin0 with enable clear
    set_pins(NP'(1) << 32);
    reg_read(8'h0C, d); check("R1 R5 rise", d, 32'h1);
    check("R6 no enable", {31'd0, irq}, 0);
    // R8: bank 3 pin 1 lives at pins_i[51]
    set_pins(pins | (NP'(1) << 51));
    reg_read(8'h1C, d); check("R8 bank3 bit1", d, 32'h2);

    // R3: zero keeps, one clears
    reg_write(8'h0C, 32'h0);
    reg_read(8'h0C, d); check("R3 zero keeps", d, 32'h1);
    reg_write(8'h0C, 32'h1); clr_model(1, 1);
    reg_read(8'h0C, d); check("R3 one clears", d, 32'h0);

    // R2: falling edge
    set_pins(pins & ~(NP'(1) << 32));
    reg_read(8'h0C, d); check("R2 fall", d, 32'h1);

    // R6: interrupt gating and one-cycle deassert
    reg_write(8'h10, 32'h1); en_model(1, 1);
    gen = 1; cyc(2);
    check("R6 assert", {31'd0, irq}, 1);
    gen = 0; cyc(1);
    check("R6 global gate", {31'd0, irq}, 0);
    gen = 1; cyc(2);
    @(negedge clk); addr = 8'h0C; wdata = 32'h1; wr = 1;
    @(negedge clk); wr = 0; clr_model(1, 1);
    check("R6 still high one cycle", {31'd0, irq}, 1);
    @(negedge clk);
    check("R6 deassert", {31'd0, irq}, 0);

    // R4: edge meets clear on the same edge
    reg_write(8'h14, 32'h4);
    @(negedge clk); pins[44] = 1'b1; m_st[44] = 1'b1;
    cyc(2);
    addr = 8'h14; wdata = 32'h4; wr = 1;
    @(negedge clk); wr = 0;
    reg_read(8'h14, d); check("R4 edge wins", d, 32'h4);

    // R7: status reset clears all banks
    set_pins(pins ^ {2'b11, 2'b01, 8'h81, 10'h201, 32'h8000_0001});
    @(negedge clk); sreset = 1;
    @(negedge clk); sreset = 0; m_st = '0;
    cyc(1);
    check_all("R7 clear all");

    // R7: reset beats a same-cycle edge
    @(negedge clk); pins[0] = ~pins[0];
    cyc(2); sreset = 1;
    @(negedge clk); sreset = 0;
    reg_read(8'h04, d); check("R7 beats edge", d, 0);

    // Random mix, R1 R2 R3 R5 R6
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 5);
      int b = $urandom_range(0, 4);
      logic [31:0] r = $urandom;
      if (op <= 1) set_pins(pins ^ (NP'({$urandom, $urandom}) & NP'({$urandom, $urandom}) & NP'({$urandom, $urandom})));
      else if (op == 2) begin reg_write(8'(4 + 8 * b), r); clr_model(b, r); end
      else if (op == 3) begin reg_write(8'(8 + 8 * b), r); en_model(b, r); end
      else if (op == 4) begin @(negedge clk); gen = $urandom_range(0, 1); end
      else set_pins(pins ^ (NP'(1) << $urandom_range(0, NP - 1)));
      cyc(2);
      if (it % 10 == 0) check_all("R1 R2 R3 R5 random");
      else check("R6 random irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule